// File: doc/BRIEF.md
# Eight-Bit ALU with Per-Operation Flag Update

This block is the arithmetic and logic stage of a small accumulator-style processor. It takes a first operand (always a register) and a second operand (another register or an immediate, selected upstream), and an operation code. It produces an 8-bit result and a write-back enable for the register file in the same cycle. It also holds the processor's zero, carry, overflow and sign flags in a register. That register is updated on the clock edge that ends the operation.

Each operation touches only its own set of flags:
- Bitwise operations renew zero and sign and leave carry and overflow alone.
- Add, subtract, increment, decrement and compare renew all four flags.
- Compare never enables write-back.
- Three flag-only operations clear carry, set carry or clear overflow, and nothing else.

Fetch, decode, the register file and memory are outside the block.

Top module: `flagalu_top`

## Requirements
- R1: With `op_valid` high, AND (code 1), OR (code 2) and XOR (code 3) put the bitwise result of `opnd_a` and `opnd_b` on `result` in the same cycle, with `wb_en` high.
- R2: A bitwise operation sets `flag_z` and `flag_s` from its result at the next clock edge, and leaves `flag_c` and `flag_v` at their previous values.
- R3: ADD (code 6) gives `result` = (`opnd_a` + `opnd_b`) mod 256 with `wb_en` high. At the next edge, `flag_c` is the unsigned carry out of bit 7. `flag_v` is set when both operands have the same sign bit and the result's sign bit differs from it.
- R4: SUB (code 7) gives `result` = (`opnd_a` − `opnd_b`) mod 256 with `wb_en` high. At the next edge, `flag_c` is set exactly when `opnd_a` < `opnd_b` unsigned (a borrow). `flag_v` is set when the operands' sign bits differ and the result's sign bit differs from `opnd_a`'s.
- R5: CMP (code 8) updates all four flags exactly as SUB would, while `wb_en` stays low.
- R6: INC (code 4) and DEC (code 5) ignore `opnd_b` and give `opnd_a` + 1 and `opnd_a` − 1 with `wb_en` high. INC sets carry only from 0xFF and overflow only from 0x7F. DEC sets carry only from 0x00 and overflow only from 0x80.
- R7: For every operation that produces a value (codes 1 to 8), `flag_z` becomes 1 exactly when the 8-bit result is 0x00, and `flag_s` becomes bit 7 of the result.
- R8: The flag-only operations each change one flag and hold the other three, with `wb_en` low:
  - code 9 clears carry;
  - code 10 sets carry;
  - code 11 clears overflow.
- R9: With `op_valid` low, or with code 0 or any code from 12 to 15, `wb_en` is low and no flag changes.
- R10: While `rst_n` is low, all four flags are cleared, and they read 0 after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the flag register updates on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the flag register |
| op_valid | input | 1 | Operation present this cycle |
| op_sel | input | 4 | Operation code (see requirements) |
| opnd_a | input | 8 | First operand, the destination register's value |
| opnd_b | input | 8 | Second operand, register or immediate |
| result | output | 8 | Combinational operation result |
| wb_en | output | 1 | Write `result` back to the first operand's register |
| flag_z | output | 1 | Registered zero flag |
| flag_c | output | 1 | Registered carry/borrow flag |
| flag_v | output | 1 | Registered signed-overflow flag |
| flag_s | output | 1 | Registered sign flag |

## Verification
`result` and `wb_en` are combinational, so they are due in the same cycle as the operands. The bench drives each operation on a falling edge and compares these two outputs one time unit later, before any rising edge. The flags are due one rising edge after the operation. The bench therefore compares them on the following falling edge, against a flag model it keeps itself, and drops `op_valid` at that same falling edge. This means each operation is counted once.

// File: rtl/flagalu_pkg.sv
package flagalu_pkg;

   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_NOP  = 4'd0,
      OP_AND  = 4'd1,
      OP_OR   = 4'd2,
      OP_XOR  = 4'd3,
      OP_INC  = 4'd4,
      OP_DEC  = 4'd5,
      OP_ADD  = 4'd6,
      OP_SUB  = 4'd7,
      OP_CMP  = 4'd8,
      OP_CLRC = 4'd9,
      OP_SETC = 4'd10,
      OP_CLRV = 4'd11
   } alu_op_e;

   typedef struct packed {
      logic z;
      logic c;
      logic v;
      logic s;
   } flags_t;

   function automatic logic op_is_bitwise(input alu_op_e op);
      return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
   endfunction

   function automatic logic op_is_arith(input alu_op_e op);
      return (op == OP_INC) || (op == OP_DEC) || (op == OP_ADD) ||
             (op == OP_SUB) || (op == OP_CMP);
   endfunction

   function automatic logic op_is_flagonly(input alu_op_e op);
      return (op == OP_CLRC) || (op == OP_SETC) || (op == OP_CLRV);
   endfunction

   function automatic logic op_writes_back(input alu_op_e op);
      return op_is_bitwise(op) || (op_is_arith(op) && op != OP_CMP);
   endfunction

endpackage

// File: rtl/flagalu_bitwise.sv
module flagalu_bitwise
   import flagalu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  alu_op_e           op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] res
);

   always_comb begin
      unique case (op)
         OP_AND:  res = a & b;
         OP_OR:   res = a | b;
         OP_XOR:  res = a ^ b;
         default: res = '0;
      endcase
   end

endmodule

// File: rtl/flagalu_arith.sv
module flagalu_arith
   import flagalu_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter bit RIPPLE_ADD = 1'b0
) (
   input  alu_op_e           op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] res,
   output logic              carry,
   output logic              ovf
);

   localparam int MSB = DATA_W - 1;
   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

   logic [DATA_W-1:0] b_eff;
   logic [DATA_W-1:0] b_in;
   logic              do_sub;
   logic              c_top;

   always_comb begin
      unique case (op)
         OP_INC:          begin b_eff = ONE; do_sub = 1'b0; end
         OP_DEC:          begin b_eff = ONE; do_sub = 1'b1; end
         OP_SUB, OP_CMP:  begin b_eff = b;   do_sub = 1'b1; end
         default:         begin b_eff = b;   do_sub = 1'b0; end
      endcase
      b_in = do_sub ? ~b_eff : b_eff;
   end

   generate
      if (RIPPLE_ADD) begin : g_ripple
         logic [DATA_W:0] cy;
         assign cy[0] = do_sub;
         for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            assign res[i]  = a[i] ^ b_in[i] ^ cy[i];
            assign cy[i+1] = (a[i] & b_in[i]) | (cy[i] & (a[i] ^ b_in[i]));
         end
         assign c_top = cy[DATA_W];
      end else begin : g_behav
         logic [DATA_W:0] sum;
         assign sum   = {1'b0, a} + {1'b0, b_in} + {{DATA_W{1'b0}}, do_sub};
         assign res   = sum[MSB:0];
         assign c_top = sum[DATA_W];
      end
   endgenerate

   // Borrow is the inverse of the carry out when subtracting.
   assign carry = do_sub ? ~c_top : c_top;
   assign ovf   = (a[MSB] == b_in[MSB]) && (res[MSB] != a[MSB]);

endmodule

// File: rtl/flagalu_flagreg.sv
module flagalu_flagreg
   import flagalu_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    upd,
   input  alu_op_e op,
   input  logic    res_zero,
   input  logic    res_sign,
   input  logic    ar_carry,
   input  logic    ar_ovf,
   output flags_t  q
);

   flags_t nxt;

   always_comb begin
      nxt = q;
      if (upd) begin
         if (op_is_bitwise(op) || op_is_arith(op)) begin
            nxt.z = res_zero;
            nxt.s = res_sign;
         end
         if (op_is_arith(op)) begin
            nxt.c = ar_carry;
            nxt.v = ar_ovf;
         end
         unique case (op)
            OP_CLRC: nxt.c = 1'b0;
            OP_SETC: nxt.c = 1'b1;
            OP_CLRV: nxt.v = 1'b0;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end

   assert_bitwise_keeps_cv_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && op_is_bitwise(op)) |=> (q.c == $past(q.c)) && (q.v == $past(q.v)));

   assert_flagop_keeps_zs_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && op_is_flagonly(op)) |=> (q.z == $past(q.z)) && (q.s == $past(q.s)));

   assert_setc_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && op == OP_SETC) |=> q.c);

   assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd) |=> $stable(q));

   assert_reset_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (q == '0));

endmodule

// File: rtl/flagalu_top.sv
module flagalu_top
   import flagalu_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter bit RIPPLE_ADD = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [3:0]        op_sel,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   output logic [DATA_W-1:0] result,
   output logic              wb_en,
   output logic              flag_z,
   output logic              flag_c,
   output logic              flag_v,
   output logic              flag_s
);

   localparam int MSB = DATA_W - 1;

   initial begin
      if (DATA_W < 2) $error("flagalu_top: DATA_W must be at least 2");
   end

   alu_op_e           op;
   logic [DATA_W-1:0] bw_res;
   logic [DATA_W-1:0] ar_res;
   logic              ar_carry;
   logic              ar_ovf;
   flags_t            fq;

   assign op = alu_op_e'(op_sel);

   flagalu_bitwise #(.DATA_W(DATA_W)) u_bitwise (
      .op (op),
      .a  (opnd_a),
      .b  (opnd_b),
      .res(bw_res)
   );

   flagalu_arith #(.DATA_W(DATA_W), .RIPPLE_ADD(RIPPLE_ADD)) u_arith (
      .op   (op),
      .a    (opnd_a),
      .b    (opnd_b),
      .res  (ar_res),
      .carry(ar_carry),
      .ovf  (ar_ovf)
   );

   always_comb begin
      if (op_is_bitwise(op))    result = bw_res;
      else if (op_is_arith(op)) result = ar_res;
      else                      result = '0;
   end

   assign wb_en = op_valid && op_writes_back(op);

   flagalu_flagreg u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .upd     (op_valid),
      .op      (op),
      .res_zero(result == '0),
      .res_sign(result[MSB]),
      .ar_carry(ar_carry),
      .ar_ovf  (ar_ovf),
      .q       (fq)
   );

   assign flag_z = fq.z;
   assign flag_c = fq.c;
   assign flag_v = fq.v;
   assign flag_s = fq.s;

   assert_zero_tracks_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && wb_en) |=> (flag_z == ($past(result) == '0)));

   assert_add_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op == OP_ADD) |=>
         (flag_c == (({1'b0, $past(opnd_a)} + {1'b0, $past(opnd_b)}) > {1'b0, {DATA_W{1'b1}}})));

   assert_cmp_borrow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op == OP_CMP) |=> (flag_c == ($past(opnd_a) < $past(opnd_b))));

   assert_no_wb_on_flagop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_is_flagonly(op)) |-> !wb_en);

endmodule

// File: tb/tb_flagalu_top.sv
module tb_flagalu_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_valid = 1'b0;
   logic [3:0] op_sel = 4'd0;
   logic [7:0] opnd_a = 8'd0;
   logic [7:0] opnd_b = 8'd0;
   logic [7:0] result;
   logic       wb_en;
   logic       flag_z, flag_c, flag_v, flag_s;

   int n_chk = 0;
   int n_bad = 0;

   // model flags, packed as {z,c,v,s}
   logic [3:0] mf = 4'b0000;

   always #4 clk = ~clk;

   flagalu_top dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result), .wb_en(wb_en),
      .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v), .flag_s(flag_s)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Apply one operation, check combinational outputs, then flags.
   task automatic run_op(input string req, input logic vld, input logic [3:0] op,
                         input logic [7:0] a, input logic [7:0] b);
      logic [7:0] r;
      logic       we, has_res;
      logic [3:0] nf;
      r = 8'h00; we = 1'b0; has_res = 1'b0; nf = mf;
      case (op)
         4'd1: begin r = a & b; we = 1; has_res = 1; end
         4'd2: begin r = a | b; we = 1; has_res = 1; end
         4'd3: begin r = a ^ b; we = 1; has_res = 1; end
         4'd4: begin r = a + 8'd1; we = 1; has_res = 1;
                     nf[2] = (a == 8'hFF); nf[1] = (a == 8'h7F); end
         4'd5: begin r = a - 8'd1; we = 1; has_res = 1;
                     nf[2] = (a == 8'h00); nf[1] = (a == 8'h80); end
         4'd6: begin r = a + b; we = 1; has_res = 1;
                     nf[2] = ({1'b0, a} + {1'b0, b}) > 9'd255;
                     nf[1] = (a[7] == b[7]) && (r[7] != a[7]); end
         4'd7, 4'd8: begin r = a - b; we = (op == 4'd7); has_res = 1;
                     nf[2] = (a < b);
                     nf[1] = (a[7] != b[7]) && (r[7] != a[7]); end
         4'd9:  nf[2] = 1'b0;
         4'd10: nf[2] = 1'b1;
         4'd11: nf[1] = 1'b0;
         default: ;
      endcase
      if (has_res) begin nf[3] = (r == 8'h00); nf[0] = r[7]; end
      if (!vld) begin nf = mf; we = 1'b0; end
      @(negedge clk);
      op_valid = vld; op_sel = op; opnd_a = a; opnd_b = b;
      #1;
      if (has_res) check(req, "result", 32'(result), 32'(r));
      check(req, "wb_en", 32'(wb_en), 32'(we));
      @(negedge clk);
      op_valid = 1'b0;
      check(req, "flags zcvs", 32'({flag_z, flag_c, flag_v, flag_s}), 32'(nf));
      mf = nf;
   endtask

   task automatic t_reset_r10();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      mf = 4'b0000;
      check("R10", "flags after reset", 32'({flag_z, flag_c, flag_v, flag_s}), 32'h0);
   endtask

   task automatic t_bitwise_r1_r2();
      run_op("R10", 1, 4'd10, 8'h00, 8'h00);      // set carry first
      run_op("R1", 1, 4'd1, 8'hF0, 8'h3C);
      run_op("R1", 1, 4'd2, 8'h81, 8'h10);
      run_op("R2", 1, 4'd3, 8'h5A, 8'h5A);        // zero result, C held at 1
      run_op("R6", 1, 4'd4, 8'h7F, 8'h00);        // sets V
      run_op("R2", 1, 4'd1, 8'h0F, 8'hF0);        // C,V must stay
   endtask

   task automatic t_add_r3();
      run_op("R3", 1, 4'd6, 8'h12, 8'h34);
      run_op("R3", 1, 4'd6, 8'hFF, 8'h01);        // carry, zero
      run_op("R3", 1, 4'd6, 8'h40, 8'h40);        // signed overflow
      run_op("R3", 1, 4'd6, 8'h80, 8'h80);        // carry + overflow, zero
      run_op("R7", 1, 4'd6, 8'hF0, 8'h05);        // sign
   endtask

   task automatic t_sub_r4_r5();
      run_op("R4", 1, 4'd7, 8'h50, 8'h20);
      run_op("R4", 1, 4'd7, 8'h20, 8'h50);        // borrow
      run_op("R4", 1, 4'd7, 8'h80, 8'h01);        // overflow
      run_op("R5", 1, 4'd8, 8'h33, 8'h33);        // equal
      run_op("R5", 1, 4'd8, 8'h01, 8'h02);        // borrow, no wb
      run_op("R5", 1, 4'd8, 8'h7F, 8'hFF);        // overflow
   endtask

   task automatic t_incdec_r6();
      run_op("R6", 1, 4'd4, 8'hFF, 8'hAA);
      run_op("R6", 1, 4'd4, 8'h10, 8'hFF);
      run_op("R6", 1, 4'd5, 8'h00, 8'h12);
      run_op("R6", 1, 4'd5, 8'h80, 8'h00);
      run_op("R6", 1, 4'd5, 8'h01, 8'h77);
   endtask

   task automatic t_flagops_r8();
      run_op("R8", 1, 4'd6, 8'hC0, 8'hC0);        // C=1, S=1
      run_op("R8", 1, 4'd9, 8'h00, 8'h00);
      run_op("R8", 1, 4'd10, 8'h00, 8'h00);
      run_op("R8", 1, 4'd6, 8'h40, 8'h40);        // V=1
      run_op("R8", 1, 4'd11, 8'hFF, 8'hFF);
   endtask

   task automatic t_idle_r9();
      run_op("R9", 1, 4'd10, 8'h00, 8'h00);
      run_op("R9", 0, 4'd6, 8'hFF, 8'h01);        // not valid
      run_op("R9", 1, 4'd0, 8'h00, 8'h00);
      run_op("R9", 1, 4'd13, 8'h00, 8'h00);
      run_op("R9", 1, 4'd15, 8'h80, 8'h80);
   endtask

   initial begin
      #400000;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_reset_r10();
      t_bitwise_r1_r2();
      t_add_r3();
      t_sub_r4_r5();
      t_incdec_r6();
      t_flagops_r8();
      t_idle_r9();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule